// File: doc/BRIEF.md
# Latency-Timed Wakeup and Select Scheduler

This block is the issue stage of a small out-of-order core. Each slot stores one waiting operation: two source tags with a ready flag apiece, a destination tag and an execution latency. A slot whose sources are both ready requests issue. A selector grants up to a fixed number of requests per cycle, with the lowest slot index taking priority. The block never sees result values. When an operation issues, a per-slot age counter starts. In the cycle the age equals the latency, the destination tag is driven on that slot's wakeup bus. Every slot compares its source tags against all wakeup buses and marks the matching sources ready.

A load always issues with the predicted hit latency. The cache reports hit or miss, with the load's tag, exactly one cycle after the predicted wakeup. On a hit the load leaves the scheduler. On a miss, every slot that names the load's tag as a source loses that ready flag and, if it has already issued, returns to the waiting state. No other slot is disturbed. The load keeps its slot and drives its tag again when the miss latency has elapsed, which wakes the returned dependents a second time.

Top module: `lat_sched`

## Requirements
- R1: After reset no issue lane and no wakeup bus is active, and `allocReady` is 1.
- R2: A new operation is written into the lowest-numbered free slot. `allocReady` is 0 exactly when every slot is occupied.
- R3: An operation issues in the first cycle in which both of its sources are ready and it holds a grant. Its destination tag appears on an issue lane in that cycle, and it does not issue again unless a miss returns it.
- R4: At most `GRANTS` operations issue per cycle. When more slots request, the lower slot indices win and the rest issue in later cycles. Lanes are filled from lane 0 upward.
- R5: A non-load with latency N that issues in cycle t drives its destination tag on its wakeup bus only in cycle t+N, and its slot is free from cycle t+N+1.
- R6: A wakeup sets the ready flag of every matching source, including a source of an operation written in the same cycle as the wakeup. A dependent whose other source is ready issues in the next cycle.
- R7: A load ignores `allocLat` and drives its wakeup in cycle t+`HIT_LAT` after issuing in cycle t.
- R8: The outcome for a load issued in cycle t arrives in cycle t+`HIT_LAT`+1 (`resMiss`=0 means hit). On a hit the load makes no further wakeup and its dependents carry on unchanged.
- R9: On a miss, only slots with a source equal to `resTag` clear that ready flag. If such a slot already issued, including in the outcome cycle itself, it is returned and issues again later. Other slots and their timing are unaffected.
- R10: After a miss the load drives its wakeup again in cycle t+`MISS_LAT`. Its returned dependents issue no earlier than the following cycle, so no dependent wakes before the load's actual latency has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Write a new operation this cycle |
| allocLoad | input | 1 | New operation is a load |
| allocLat | input | LAT_W | Execution latency of a non-load (1 to MISS_LAT) |
| allocSrcA | input | TAG_W | First source tag |
| allocRdyA | input | 1 | First source already available |
| allocSrcB | input | TAG_W | Second source tag |
| allocRdyB | input | 1 | Second source already available |
| allocDst | input | TAG_W | Destination tag |
| allocReady | output | 1 | At least one slot is free |
| resValid | input | 1 | Cache outcome for a load is present |
| resMiss | input | 1 | Outcome is a miss (0 = hit) |
| resTag | input | TAG_W | Destination tag of the load the outcome belongs to |
| issueValid | output | GRANTS | Issue lane active |
| issueTag | output | GRANTS*TAG_W | Destination tag per issue lane, lane 0 in the low bits |
| wakeValid | output | ENTRIES | Wakeup bus active, one per slot |
| wakeTag | output | ENTRIES*TAG_W | Tag per wakeup bus, slot 0 in the low bits |

## Verification
A stale ready flag after a miss shows up on the issue lanes one cycle after the outcome. The dependent then appears a second time too early, or its own wakeup arrives before the load's second wakeup. An age counter or latency field that is off by one moves a wakeup by a cycle, and every later dependent issue moves with it. A slot that is never freed shows up as `allocReady` staying low, or as a wakeup that repeats. The directed scenarios record the cycle of every issue and wakeup per tag and compare those cycles with values derived from the latencies.

// File: rtl/lat_sched_pkg.sv
package lat_sched_pkg;

  // Strobes decoded by the control path and consumed by the slot array.
  typedef struct packed {
    logic allocEn;  // a write into the selected free slot happens
    logic missEn;   // cache outcome says miss for resTag
    logic hitEn;    // cache outcome says hit for resTag
  } schedStrobe_t;

endpackage

// File: rtl/lat_sched_ctrl.sv
module lat_sched_ctrl
  import lat_sched_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int GRANTS  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRIES-1:0] reqVec,
  input  logic [ENTRIES-1:0] freeVec,
  input  logic               allocValid,
  input  logic               resValid,
  input  logic               resMiss,
  output logic [ENTRIES-1:0] grantVec,
  output logic [ENTRIES-1:0] allocVec,
  output logic               allocReady,
  output schedStrobe_t       strobe
);

  // Oldest-first by position: lower index wins, up to GRANTS per cycle.
  always_comb begin
    int granted;
    granted  = 0;
    grantVec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (reqVec[i] && granted < GRANTS) begin
        grantVec[i] = 1'b1;
        granted     = granted + 1;
      end
    end
  end

  // Lowest free slot receives the next operation.
  always_comb begin
    logic found;
    found    = 1'b0;
    allocVec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (freeVec[i] && !found) begin
        allocVec[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign allocReady     = |freeVec;
  assign strobe.allocEn = allocValid && (|freeVec);
  assign strobe.missEn  = resValid && resMiss;
  assign strobe.hitEn   = resValid && !resMiss;

  // R4: grants never exceed the lane count
  a_r4_grant_cap: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grantVec) <= GRANTS);

endmodule

// File: rtl/lat_sched_data.sv
module lat_sched_data
  import lat_sched_pkg::*;
#(
  parameter int ENTRIES  = 4,
  parameter int GRANTS   = 2,
  parameter int TAG_W    = 4,
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 8,
  parameter int LAT_W    = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  schedStrobe_t              strobe,
  input  logic [ENTRIES-1:0]        allocVec,
  input  logic [ENTRIES-1:0]        grantVec,
  input  logic                      allocLoad,
  input  logic [LAT_W-1:0]          allocLat,
  input  logic [TAG_W-1:0]          allocSrcA,
  input  logic                      allocRdyA,
  input  logic [TAG_W-1:0]          allocSrcB,
  input  logic                      allocRdyB,
  input  logic [TAG_W-1:0]          allocDst,
  input  logic [TAG_W-1:0]          resTag,
  output logic [ENTRIES-1:0]        reqVec,
  output logic [ENTRIES-1:0]        freeVec,
  output logic [GRANTS-1:0]         issueValid,
  output logic [GRANTS*TAG_W-1:0]   issueTag,
  output logic [ENTRIES-1:0]        wakeValid,
  output logic [ENTRIES*TAG_W-1:0]  wakeTag
);

  localparam logic [LAT_W-1:0] HIT_L  = LAT_W'(HIT_LAT);
  localparam logic [LAT_W-1:0] MISS_L = LAT_W'(MISS_LAT);
  localparam logic [LAT_W-1:0] PROBE_L = LAT_W'(HIT_LAT + 1);

  logic [ENTRIES-1:0] validQ, issuedQ, loadQ, rdyAQ, rdyBQ;
  logic [TAG_W-1:0]   srcAQ [ENTRIES];
  logic [TAG_W-1:0]   srcBQ [ENTRIES];
  logic [TAG_W-1:0]   dstQ  [ENTRIES];
  logic [LAT_W-1:0]   latQ  [ENTRIES];
  logic [LAT_W-1:0]   ageQ  [ENTRIES];

  logic [ENTRIES-1:0] bcast, wakeA, wakeB, missA, missB, selfMiss, selfHit, release_;
  logic               allocWakeA, allocWakeB, outcomeOk;

  // A slot broadcasts when its age since issue reaches its latency.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      bcast[i] = validQ[i] && issuedQ[i] && (ageQ[i] == latQ[i]);
  end

  // Tag compare against every wakeup bus, plus miss and outcome decode.
  always_comb begin
    allocWakeA = 1'b0;
    allocWakeB = 1'b0;
    outcomeOk  = 1'b0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (bcast[j] && dstQ[j] == allocSrcA) allocWakeA = 1'b1;
      if (bcast[j] && dstQ[j] == allocSrcB) allocWakeB = 1'b1;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      wakeA[i] = 1'b0;
      wakeB[i] = 1'b0;
      for (int j = 0; j < ENTRIES; j++) begin
        if (bcast[j] && dstQ[j] == srcAQ[i]) wakeA[i] = 1'b1;
        if (bcast[j] && dstQ[j] == srcBQ[i]) wakeB[i] = 1'b1;
      end
      missA[i]    = strobe.missEn && validQ[i] && (srcAQ[i] == resTag);
      missB[i]    = strobe.missEn && validQ[i] && (srcBQ[i] == resTag);
      selfMiss[i] = strobe.missEn && validQ[i] && loadQ[i] && (dstQ[i] == resTag);
      selfHit[i]  = strobe.hitEn  && validQ[i] && loadQ[i] && (dstQ[i] == resTag);
      release_[i] = (bcast[i] && (!loadQ[i] || latQ[i] == MISS_L)) || selfHit[i];
      if (validQ[i] && loadQ[i] && issuedQ[i] && dstQ[i] == resTag && ageQ[i] == PROBE_L)
        outcomeOk = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= '0;
      issuedQ <= '0;
      loadQ   <= '0;
      rdyAQ   <= '0;
      rdyBQ   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        srcAQ[i] <= '0;
        srcBQ[i] <= '0;
        dstQ[i]  <= '0;
        latQ[i]  <= '0;
        ageQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.allocEn && allocVec[i]) begin
          validQ[i]  <= 1'b1;
          issuedQ[i] <= 1'b0;
          loadQ[i]   <= allocLoad;
          srcAQ[i]   <= allocSrcA;
          srcBQ[i]   <= allocSrcB;
          dstQ[i]    <= allocDst;
          rdyAQ[i]   <= allocRdyA || allocWakeA;
          rdyBQ[i]   <= allocRdyB || allocWakeB;
          latQ[i]    <= allocLoad ? HIT_L : allocLat;
          ageQ[i]    <= '0;
        end else if (validQ[i]) begin
          if (wakeA[i]) rdyAQ[i] <= 1'b1;
          if (wakeB[i]) rdyBQ[i] <= 1'b1;
          if (grantVec[i]) begin
            issuedQ[i] <= 1'b1;
            ageQ[i]    <= LAT_W'(1);
          end else if (issuedQ[i] && ageQ[i] != '1) begin
            ageQ[i] <= ageQ[i] + 1'b1;
          end
          if (selfMiss[i]) latQ[i] <= MISS_L;
          // Selective replay: only consumers of the missing tag go back.
          if (missA[i] || missB[i]) begin
            if (missA[i]) rdyAQ[i] <= 1'b0;
            if (missB[i]) rdyBQ[i] <= 1'b0;
            issuedQ[i] <= 1'b0;
            ageQ[i]    <= '0;
          end
          if (release_[i]) begin
            validQ[i]  <= 1'b0;
            issuedQ[i] <= 1'b0;
          end
        end
      end
    end
  end

  assign reqVec  = validQ & ~issuedQ & rdyAQ & rdyBQ;
  assign freeVec = ~validQ;

  // Pack granted slots onto lanes, lowest slot first.
  always_comb begin
    logic [ENTRIES-1:0] left;
    logic               pick;
    left       = grantVec;
    issueValid = '0;
    issueTag   = '0;
    for (int l = 0; l < GRANTS; l++) begin
      pick = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (left[i] && !pick) begin
          pick                         = 1'b1;
          left[i]                      = 1'b0;
          issueValid[l]                = 1'b1;
          issueTag[l*TAG_W +: TAG_W]   = dstQ[i];
        end
      end
    end
  end

  always_comb begin
    wakeValid = bcast;
    for (int i = 0; i < ENTRIES; i++)
      wakeTag[i*TAG_W +: TAG_W] = dstQ[i];
  end

  // R8: an outcome always refers to a load one cycle past its predicted wakeup
  a_r8_outcome_match: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hitEn || strobe.missEn) |-> outcomeOk);

  for (genvar g = 0; g < ENTRIES; g++) begin : gChk
    // R2: writes only land in an unoccupied slot
    a_r2_alloc_free: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.allocEn && allocVec[g]) |-> !validQ[g]);
    // R3: a granted slot stops requesting
    a_r3_no_reissue: assert property (@(posedge clk) disable iff (!rstN)
      grantVec[g] |=> !reqVec[g]);
    // R5: a non-load slot is released after its wakeup
    a_r5_slot_release: assert property (@(posedge clk) disable iff (!rstN)
      (bcast[g] && !loadQ[g]) |=> !validQ[g]);
    // R9: a consumer of a missing tag returns to waiting
    a_r9_squash_clear: assert property (@(posedge clk) disable iff (!rstN)
      (missA[g] || missB[g]) |=> (!issuedQ[g] && !reqVec[g]));
  end

endmodule

// File: rtl/lat_sched.sv
module lat_sched
  import lat_sched_pkg::*;
#(
  parameter int ENTRIES  = 4,
  parameter int GRANTS   = 2,
  parameter int TAG_W    = 4,
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 8,
  parameter int LAT_W    = $clog2(MISS_LAT + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      allocValid,
  input  logic                      allocLoad,
  input  logic [LAT_W-1:0]          allocLat,
  input  logic [TAG_W-1:0]          allocSrcA,
  input  logic                      allocRdyA,
  input  logic [TAG_W-1:0]          allocSrcB,
  input  logic                      allocRdyB,
  input  logic [TAG_W-1:0]          allocDst,
  output logic                      allocReady,
  input  logic                      resValid,
  input  logic                      resMiss,
  input  logic [TAG_W-1:0]          resTag,
  output logic [GRANTS-1:0]         issueValid,
  output logic [GRANTS*TAG_W-1:0]   issueTag,
  output logic [ENTRIES-1:0]        wakeValid,
  output logic [ENTRIES*TAG_W-1:0]  wakeTag
);

  logic [ENTRIES-1:0] reqVec, freeVec, grantVec, allocVec;
  schedStrobe_t       strobe;

  lat_sched_ctrl #(.ENTRIES(ENTRIES), .GRANTS(GRANTS)) ctrl (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .freeVec(freeVec),
    .allocValid(allocValid), .resValid(resValid), .resMiss(resMiss),
    .grantVec(grantVec), .allocVec(allocVec), .allocReady(allocReady),
    .strobe(strobe)
  );

  lat_sched_data #(
    .ENTRIES(ENTRIES), .GRANTS(GRANTS), .TAG_W(TAG_W),
    .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT), .LAT_W(LAT_W)
  ) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocVec(allocVec),
    .grantVec(grantVec), .allocLoad(allocLoad), .allocLat(allocLat),
    .allocSrcA(allocSrcA), .allocRdyA(allocRdyA), .allocSrcB(allocSrcB),
    .allocRdyB(allocRdyB), .allocDst(allocDst), .resTag(resTag),
    .reqVec(reqVec), .freeVec(freeVec), .issueValid(issueValid),
    .issueTag(issueTag), .wakeValid(wakeValid), .wakeTag(wakeTag)
  );

endmodule

// File: tb/lat_sched_test.sv
module lat_sched_test;

  localparam int CLK_PERIOD = 10;
  localparam int E  = 4;
  localparam int G  = 2;
  localparam int TW = 4;
  localparam int LW = 4;
  localparam int HIT  = 2;
  localparam int MISS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0, allocLoad = 1'b0, allocRdyA = 1'b0, allocRdyB = 1'b0;
  logic [LW-1:0] allocLat = '0;
  logic [TW-1:0] allocSrcA = '0, allocSrcB = '0, allocDst = '0, resTag = '0;
  logic resValid = 1'b0, resMiss = 1'b0;
  logic allocReady;
  logic [G-1:0]    issueValid;
  logic [G*TW-1:0] issueTag;
  logic [E-1:0]    wakeValid;
  logic [E*TW-1:0] wakeTag;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  int issueCnt [16];
  int lastIssue[16];
  int wakeCnt  [16];
  int firstWake[16];
  int lastWake [16];

  lat_sched #(.ENTRIES(E), .GRANTS(G), .TAG_W(TW), .HIT_LAT(HIT), .MISS_LAT(MISS)) uut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocLoad(allocLoad),
    .allocLat(allocLat), .allocSrcA(allocSrcA), .allocRdyA(allocRdyA),
    .allocSrcB(allocSrcB), .allocRdyB(allocRdyB), .allocDst(allocDst),
    .allocReady(allocReady), .resValid(resValid), .resMiss(resMiss),
    .resTag(resTag), .issueValid(issueValid), .issueTag(issueTag),
    .wakeValid(wakeValid), .wakeTag(wakeTag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Event log per tag, sampled mid-cycle.
  always @(negedge clk) begin
    if (rstN) begin
      for (int l = 0; l < G; l++) begin
        if (issueValid[l]) begin
          issueCnt[issueTag[l*TW +: TW]]  += 1;
          lastIssue[issueTag[l*TW +: TW]] = cyc;
        end
      end
      for (int i = 0; i < E; i++) begin
        if (wakeValid[i]) begin
          if (wakeCnt[wakeTag[i*TW +: TW]] == 0) firstWake[wakeTag[i*TW +: TW]] = cyc;
          wakeCnt[wakeTag[i*TW +: TW]]  += 1;
          lastWake[wakeTag[i*TW +: TW]] = cyc;
        end
      end
    end
  end

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic clearLog();
    for (int k = 0; k < 16; k++) begin
      issueCnt[k] = 0; lastIssue[k] = -1;
      wakeCnt[k] = 0; firstWake[k] = -1; lastWake[k] = -1;
    end
  endtask

  task automatic waitCyc(input int c);
    while (cyc < c) begin @(posedge clk); #1; end
  endtask

  task automatic allocOne(input logic ld, input int lat, input int sa, input logic ra,
                          input int sb, input logic rb, input int dst);
    allocValid = 1'b1; allocLoad = ld; allocLat = LW'(lat);
    allocSrcA = TW'(sa); allocRdyA = ra; allocSrcB = TW'(sb); allocRdyB = rb;
    allocDst = TW'(dst);
    @(posedge clk); #1;
    allocValid = 1'b0;
  endtask

  task automatic outcome(input logic miss, input int tag);
    resValid = 1'b1; resMiss = miss; resTag = TW'(tag);
    @(posedge clk); #1;
    resValid = 1'b0;
  endtask

  task automatic testReset();
    check("R1 allocReady", int'(allocReady), 1);
    check("R1 issue idle", int'(issueValid), 0);
    check("R1 wake idle", int'(wakeValid), 0);
  endtask

  task automatic testSimple();
    int t;
    clearLog();
    allocOne(1'b0, 3, 0, 1'b1, 0, 1'b1, 1);
    t = cyc;
    waitCyc(t + 8);
    check("R3 issue cycle", lastIssue[1], t);
    check("R3 single issue", issueCnt[1], 1);
    check("R5 wake at t+3", lastWake[1], t + 3);
    check("R5 single wake", wakeCnt[1], 1);
  endtask

  task automatic testBypass();
    int a;
    clearLog();
    allocOne(1'b0, 4, 0, 1'b1, 0, 1'b1, 2);
    a = cyc;
    waitCyc(a + 4);                       // alloc during producer's wakeup cycle
    allocOne(1'b0, 2, 2, 1'b0, 0, 1'b1, 3);
    waitCyc(a + 12);
    check("R5 producer wake", lastWake[2], a + 4);
    check("R6 bypass issue", lastIssue[3], a + 5);
    check("R6 dependent wake", lastWake[3], a + 7);
  endtask

  task automatic testPriority();
    int p;
    clearLog();
    allocOne(1'b0, 1, 5, 1'b0, 0, 1'b1, 6);
    allocOne(1'b0, 1, 5, 1'b0, 0, 1'b1, 7);
    allocOne(1'b0, 1, 5, 1'b0, 0, 1'b1, 8);
    allocOne(1'b0, 2, 0, 1'b1, 0, 1'b1, 5);
    p = cyc;
    check("R2 full", int'(allocReady), 0);
    waitCyc(p + 10);
    check("R6 producer wake", lastWake[5], p + 2);
    check("R4 slot0 issue", lastIssue[6], p + 3);
    check("R4 slot1 issue", lastIssue[7], p + 3);
    check("R4 slot2 deferred", lastIssue[8], p + 4);
    check("R2 drained", int'(allocReady), 1);
  endtask

  task automatic testLoadHit();
    int t;
    clearLog();
    allocOne(1'b0, 1, 9, 1'b0, 0, 1'b1, 10);
    allocOne(1'b1, 7, 0, 1'b1, 0, 1'b1, 9);
    t = cyc;
    waitCyc(t + HIT + 1);
    outcome(1'b0, 9);
    waitCyc(t + 14);
    check("R7 load issue", lastIssue[9], t);
    check("R7 load wake at hit latency", firstWake[9], t + HIT);
    check("R8 no second wake", wakeCnt[9], 1);
    check("R8 dependent issue", lastIssue[10], t + HIT + 1);
    check("R8 dependent kept", issueCnt[10], 1);
    check("R8 dependent wake", lastWake[10], t + HIT + 2);
  endtask

  task automatic testLoadMiss();
    int t;
    clearLog();
    allocOne(1'b0, 1, 11, 1'b0, 0, 1'b1, 12);   // dependent
    allocOne(1'b0, 1, 12, 1'b0, 0, 1'b1, 13);   // grandchild
    allocOne(1'b1, 1, 0, 1'b1, 0, 1'b1, 11);    // load
    t = cyc;
    allocOne(1'b0, 5, 0, 1'b1, 0, 1'b1, 14);    // independent
    waitCyc(t + HIT + 1);
    outcome(1'b1, 11);
    waitCyc(t + 20);
    check("R7 early wake", firstWake[11], t + HIT);
    check("R10 late wake", lastWake[11], t + MISS);
    check("R10 two wakes", wakeCnt[11], 2);
    check("R9 dependent replayed", issueCnt[12], 2);
    check("R10 replay issue", lastIssue[12], t + MISS + 1);
    check("R10 dependent single wake", wakeCnt[12], 1);
    check("R10 dependent wake", firstWake[12], t + MISS + 2);
    check("R9 grandchild single issue", issueCnt[13], 1);
    check("R10 grandchild issue", lastIssue[13], t + MISS + 3);
    check("R9 independent single issue", issueCnt[14], 1);
    check("R9 independent wake", lastWake[14], t + 6);
    check("R2 all free", int'(allocReady), 1);
  endtask

  initial begin
    clearLog();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testSimple();
    testBypass();
    testPriority();
    testLoadHit();
    testLoadMiss();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule